// File: doc/BRIEF.md
# Serial Port Transmit/Receive Word Queue Pair

This block holds two word queues between a serial port's register side and its shift engine. The transmit queue takes words written by software and hands them, oldest first, to the shift engine. The receive queue takes each character the shift engine completes and hands it back to software on a read. Each queue reports its fill level as a count wide enough to show the full state. Each queue also has its own level-match interrupt flag, cleared by a write of one. Each queue has a run bit, and while that bit is low the queue is held empty. The receive queue also keeps a sticky overflow flag.

A global enable selects queued operation. With the enable low, both queues shrink to one-word buffers and their interrupt flags are held clear. The serial shifting itself lies outside the block. Read data is registered: a word popped in one cycle appears on the data output from the next cycle on, and it stays there until the next pop.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset both counts are 0, both interrupt flags, both interrupt outputs and the overflow flag are 0, and both read-data outputs are 0.
- R2: Each queue returns words in write order. Its count steps from 0 up to 16, and a count of 16 reads as 5'b10000. A popped word appears on the read-data output one cycle after the pop.
- R3: A write to the transmit queue while it holds 16 words, with no pop in the same cycle, is ignored: the count stays 16 and the stored order is unchanged.
- R4: A character pushed into the receive queue while it holds 16 words, with no read in the same cycle, is discarded and sets the overflow flag. The flag stays set until a cycle with rx_ovf_clr=1, and a new overflow in the same cycle as a clear leaves the flag set.
- R5: A read from an empty receive queue leaves the count at 0 and leaves the read-data output at the last word read.
- R6: A push and a pop in the same cycle leave the count unchanged, and this also holds at 16 words. At 16 words the pushed word is accepted and no overflow is flagged.
- R7: A queue's interrupt flag is set in the cycle after its count equals its 5-bit level. The flag stays set while no clear is given. The interrupt output is the flag gated by that queue's interrupt enable.
- R8: A clear input of 1 drops the flag in the next cycle. A clear input of 0 has no effect. If the count still equals the level, the flag is set again one cycle later.
- R9: While a queue's run bit is 0, its count is held at 0, pushes are discarded and its flag is 0. After the run bit returns to 1, the queue starts empty.
- R10: With the global enable at 0, each queue holds at most one word and both interrupt flags stay 0, even when the count matches the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = queued operation, 0 = one-word buffers |
| tx_run | input | 1 | Transmit queue run bit (0 holds it empty) |
| tx_wr | input | 1 | Software write into the transmit queue |
| tx_wdata | input | 16 | Word written into the transmit queue |
| tx_pop | input | 1 | Shift engine takes the oldest transmit word |
| tx_rdata | output | 16 | Last word taken from the transmit queue |
| tx_count | output | 5 | Transmit fill count |
| tx_lvl | input | 5 | Transmit interrupt level |
| tx_ie | input | 1 | Transmit interrupt enable |
| tx_int_clr | input | 1 | Write-one clear of the transmit flag |
| tx_int_flag | output | 1 | Transmit interrupt flag |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_run | input | 1 | Receive queue run bit (0 holds it empty) |
| rx_push | input | 1 | Shift engine delivers a completed character |
| rx_wdata | input | 16 | Delivered character |
| rx_rd | input | 1 | Software read of the oldest receive word |
| rx_rdata | output | 16 | Last word read from the receive queue |
| rx_count | output | 5 | Receive fill count |
| rx_lvl | input | 5 | Receive interrupt level |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_int_clr | input | 1 | Write-one clear of the receive flag |
| rx_int_flag | output | 1 | Receive interrupt flag |
| rx_irq | output | 1 | Receive interrupt request |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| rx_ovf_clr | input | 1 | Write-one clear of the overflow flag |

## Verification
Two pairs of events can land in the same cycle, and the bench drives each pair in one cycle on purpose. In the first pair, a new character arrives at a full receive queue while the overflow clear is high. The bench expects the flag to remain set. In the second pair, an interrupt clear comes while the count still equals the level. The bench expects the flag low for exactly one cycle and then set again. A push that coincides with a read at 16 words is also driven. The bench judges it by the count staying at 16, the oldest word emerging and no overflow being flagged.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  // Fill count after one cycle of optional push and optional pop.
  function automatic int cnt_step(input int cnt, input logic up, input logic dn);
    int r;
    r = cnt;
    if (up) r = r + 1;
    if (dn) r = r - 1;
    return r;
  endfunction

  // Ring pointer advance with wrap at the queue depth.
  function automatic int ptr_step(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // Capacity in force: one word in buffer mode, full depth otherwise.
  function automatic int capacity(input logic single, input int depth);
    return single ? 1 : depth;
  endfunction

endpackage

// File: rtl/sfp_store.sv
module sfp_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             push_ok
);
  import spi_fifo_pkg::*;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cap_w;
  logic             pop_ok;

  assign cap_w   = CW'(capacity(single, DEPTH));
  assign pop_ok  = run && pop && (count != '0);
  assign push_ok = run && push && ((count < cap_w) || pop_ok);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rdata  <= '0;
    end else if (!run) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(ptr_step(int'(wr_ptr), DEPTH));
      if (pop_ok) begin
        rd_ptr <= AW'(ptr_step(int'(rd_ptr), DEPTH));
        rdata  <= mem[rd_ptr];
      end
      count <= CW'(cnt_step(int'(count), push_ok, pop_ok));
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r3_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    run && push && !pop && count == CW'(DEPTH) |=> count == CW'(DEPTH));
  a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    run && pop && !push && count == '0 |=> $stable(rdata) && count == '0);
  a_r6_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    run && !single && push && pop && count == CW'(DEPTH) |=> count == CW'(DEPTH));
  a_r9_held_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == '0);

endmodule

// File: rtl/sfp_flag.sv
module sfp_flag #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] level,
  input  logic          clr,
  output logic          flag
);
  logic hit;
  assign hit = (count == level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (!enable) flag <= 1'b0;
    else if (clr)     flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
  end

  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && enable && !clr |=> flag);
  a_r7_sets_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !clr && hit |=> flag);

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             tx_run,
  input  logic             tx_wr,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  output logic [CW-1:0]    tx_count,
  input  logic [CW-1:0]    tx_lvl,
  input  logic             tx_ie,
  input  logic             tx_int_clr,
  output logic             tx_int_flag,
  output logic             tx_irq,
  input  logic             rx_run,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_rd,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [CW-1:0]    rx_count,
  input  logic [CW-1:0]    rx_lvl,
  input  logic             rx_ie,
  input  logic             rx_int_clr,
  output logic             rx_int_flag,
  output logic             rx_irq,
  output logic             rx_ovf,
  input  logic             rx_ovf_clr
);
  localparam int NCH = 2;
  localparam int TXC = 0;
  localparam int RXC = 1;

  logic [NCH-1:0] run_v, push_v, pop_v, clr_v, ok_v, flag_v;
  logic [WIDTH-1:0] wdata_v [NCH];
  logic [WIDTH-1:0] rdata_v [NCH];
  logic [CW-1:0]    cnt_v   [NCH];
  logic [CW-1:0]    lvl_v   [NCH];

  assign run_v  = {rx_run, tx_run};
  assign push_v = {rx_push, tx_wr};
  assign pop_v  = {rx_rd, tx_pop};
  assign clr_v  = {rx_int_clr, tx_int_clr};
  assign wdata_v[TXC] = tx_wdata;
  assign wdata_v[RXC] = rx_wdata;
  assign lvl_v[TXC]   = tx_lvl;
  assign lvl_v[RXC]   = rx_lvl;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sfp_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .run(run_v[c]), .single(!fifo_en),
      .push(push_v[c]), .wdata(wdata_v[c]), .pop(pop_v[c]),
      .rdata(rdata_v[c]), .count(cnt_v[c]), .push_ok(ok_v[c])
    );
    sfp_flag #(.CW(CW)) u_flag (
      .clk(clk), .rst_n(rst_n), .enable(fifo_en && run_v[c]),
      .count(cnt_v[c]), .level(lvl_v[c]), .clr(clr_v[c]), .flag(flag_v[c])
    );
  end

  assign tx_rdata    = rdata_v[TXC];
  assign rx_rdata    = rdata_v[RXC];
  assign tx_count    = cnt_v[TXC];
  assign rx_count    = cnt_v[RXC];
  assign tx_int_flag = flag_v[TXC];
  assign rx_int_flag = flag_v[RXC];
  assign tx_irq      = flag_v[TXC] && tx_ie;
  assign rx_irq      = flag_v[RXC] && rx_ie;

  // Named event: a received character that found no room.
  logic rx_drop;
  assign rx_drop = rx_push && rx_run && !ok_v[RXC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_ovf <= 1'b0;
    else if (rx_drop)    rx_ovf <= 1'b1;
    else if (rx_ovf_clr) rx_ovf <= 1'b0;
  end

  a_r4_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> rx_ovf);
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf && !rx_ovf_clr |=> rx_ovf);
  a_r10_flags_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !tx_int_flag && !rx_int_flag);
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ie |-> !tx_irq) and (!rx_ie |-> !rx_irq));

endmodule

// File: tb/spi_fifo_pair_tb.sv
module spi_fifo_pair_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0;
  logic tx_run = 1'b0, tx_wr = 1'b0, tx_pop = 1'b0, tx_ie = 1'b0, tx_int_clr = 1'b0;
  logic rx_run = 1'b0, rx_push = 1'b0, rx_rd = 1'b0, rx_ie = 1'b0, rx_int_clr = 1'b0;
  logic rx_ovf_clr = 1'b0;
  logic [15:0] tx_wdata = '0, rx_wdata = '0;
  logic [4:0]  tx_lvl = 5'd31, rx_lvl = 5'd31;
  logic [15:0] tx_rdata, rx_rdata;
  logic [4:0]  tx_count, rx_count;
  logic tx_int_flag, tx_irq, rx_int_flag, rx_irq, rx_ovf;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_fifo_pair u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .tx_run(tx_run), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_lvl(tx_lvl), .tx_ie(tx_ie),
    .tx_int_clr(tx_int_clr), .tx_int_flag(tx_int_flag), .tx_irq(tx_irq),
    .rx_run(rx_run), .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_lvl(rx_lvl), .rx_ie(rx_ie),
    .rx_int_clr(rx_int_clr), .rx_int_flag(rx_int_flag), .rx_irq(rx_irq),
    .rx_ovf(rx_ovf), .rx_ovf_clr(rx_ovf_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic tx_put(input logic [15:0] d);
    tx_wr = 1'b1; tx_wdata = d; tick(); tx_wr = 1'b0;
  endtask
  task automatic tx_take();
    tx_pop = 1'b1; tick(); tx_pop = 1'b0;
  endtask
  task automatic rx_put(input logic [15:0] d);
    rx_push = 1'b1; rx_wdata = d; tick(); rx_push = 1'b0;
  endtask
  task automatic rx_take();
    rx_rd = 1'b1; tick(); rx_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 flags", {tx_int_flag, rx_int_flag, tx_irq, rx_irq, rx_ovf}, 0);
    chk("R1 rdata", {tx_rdata, rx_rdata}, 0);
  endtask

  task automatic t_order_and_full();
    for (int i = 0; i < 16; i++) begin
      tx_put(16'hA000 + 16'(i));
      chk("R2 count up", tx_count, i + 1);
    end
    chk("R2 full code 10000", tx_count, 5'b10000);
    tx_put(16'hDEAD);
    chk("R3 full write ignored", tx_count, 16);
    for (int i = 0; i < 16; i++) begin
      tx_take();
      chk("R2 order", tx_rdata, 16'hA000 + i);
      chk("R2 count down", tx_count, 15 - i);
    end
  endtask

  task automatic t_empty_read();
    rx_put(16'h1111);
    rx_put(16'h2222);
    rx_take();
    rx_take();
    chk("R5 last word", rx_rdata, 16'h2222);
    rx_take();
    chk("R5 empty read keeps word", rx_rdata, 16'h2222);
    chk("R5 empty read keeps count", rx_count, 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 16; i++) rx_put(16'h5000 + 16'(i));
    chk("R4 no ovf at 16", rx_ovf, 0);
    rx_put(16'hBADD);
    chk("R4 count stays 16", rx_count, 16);
    chk("R4 ovf set", rx_ovf, 1);
    tick();
    chk("R4 ovf sticky", rx_ovf, 1);
    rx_ovf_clr = 1'b1; tick(); rx_ovf_clr = 1'b0;
    chk("R4 ovf cleared", rx_ovf, 0);
    rx_ovf_clr = 1'b1; rx_push = 1'b1; rx_wdata = 16'hBADE;
    tick();
    rx_ovf_clr = 1'b0; rx_push = 1'b0;
    chk("R4 set beats clear", rx_ovf, 1);
    rx_ovf_clr = 1'b1; tick(); rx_ovf_clr = 1'b0;
    rx_push = 1'b1; rx_rd = 1'b1; rx_wdata = 16'h6000;
    tick();
    rx_push = 1'b0; rx_rd = 1'b0;
    chk("R6 count at full swap", rx_count, 16);
    chk("R6 no ovf on swap", rx_ovf, 0);
    chk("R6 oldest out", rx_rdata, 16'h5000);
    rx_take();
    chk("R4 discarded word absent", rx_rdata, 16'h5001);
  endtask

  task automatic t_run_bit();
    rx_run = 1'b0; tick();
    chk("R9 held empty", rx_count, 0);
    rx_put(16'h7777);
    chk("R9 push discarded", rx_count, 0);
    rx_run = 1'b1; tick();
    chk("R9 restart empty", rx_count, 0);
    rx_put(16'h7878);
    rx_take();
    chk("R9 fresh data", rx_rdata, 16'h7878);
  endtask

  task automatic t_irq();
    tx_lvl = 5'd2;
    tx_put(16'h0001);
    tx_put(16'h0002);
    chk("R7 flag lags count", tx_int_flag, 0);
    tick();
    chk("R7 flag set", tx_int_flag, 1);
    chk("R7 irq gated off", tx_irq, 0);
    tx_ie = 1'b1; #1;
    chk("R7 irq on", tx_irq, 1);
    tick();
    chk("R8 clr 0 no effect", tx_int_flag, 1);
    tx_int_clr = 1'b1; tick(); tx_int_clr = 1'b0;
    chk("R8 cleared", tx_int_flag, 0);
    tick();
    chk("R8 re-set on match", tx_int_flag, 1);
    tx_take();
    tx_int_clr = 1'b1; tick(); tx_int_clr = 1'b0;
    tick();
    chk("R8 stays clear off match", tx_int_flag, 0);
    chk("R7 irq follows flag", tx_irq, 0);
    rx_run = 1'b0; tick(); rx_run = 1'b1;
    rx_lvl = 5'd1; rx_ie = 1'b1;
    rx_put(16'h4242);
    tick();
    chk("R7 rx irq", rx_irq, 1);
    rx_ie = 1'b0; rx_lvl = 5'd31;
  endtask

  task automatic t_single();
    tx_run = 1'b0; tick(); tx_run = 1'b1;
    fifo_en = 1'b0; tx_lvl = 5'd1;
    tx_put(16'hC001);
    tx_put(16'hC002);
    chk("R10 one word cap", tx_count, 1);
    tick(); tick();
    chk("R10 flag held off", tx_int_flag, 0);
    chk("R10 irq off", tx_irq, 0);
    tx_take();
    chk("R10 first word kept", tx_rdata, 16'hC001);
    chk("R10 empty after", tx_count, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    fifo_en = 1'b1; tx_run = 1'b1; rx_run = 1'b1;
    tick();
    t_order_and_full();
    t_empty_read();
    t_overflow();
    t_run_bit();
    t_irq();
    t_single();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule